// File: doc/BRIEF.md
# Hybrid Karatsuba Binary-Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M), with elements held in polynomial basis. Bit i of every operand and of the result is the coefficient of x^i. The product is formed without carries. Each operand is split in half, and the halves are split again, Karatsuba style, until a piece is no wider than a base threshold. Pieces at or below that threshold are multiplied with a plain AND/XOR array. The full double-width product then goes through a fixed pentanomial reduction. Adding two field elements is a plain XOR, so the three half products recombine without any carry chain.

A squaring request skips the multiplier entirely. The operand bits are interleaved with zeros, and the result is reduced by the same reduction network. A caller loads the operands and the squaring select together with a one-cycle `start`. The reduced result comes back with a one-cycle `done`. A new request may be issued on every cycle.

The field width, the three middle exponents of the pentanomial and the base threshold are all parameters. A small instance can therefore be checked exhaustively with the same code that builds the 163-bit default.

Top module: `gf2m_kara_mul`

## Requirements
- R1: While `rst` is high and in the cycles that follow it with no request, `done` is 0 and `result` is all zeros.
- R2: A request sampled on a rising edge gives exactly one `done` pulse, which is visible after the second rising edge from that one. No `done` pulse appears without a request.
- R3: With `sq_mode` = 0, `result` is `op_a`·`op_b` as carry-less polynomials, reduced modulo x^M + x^K3 + x^K2 + x^K1 + 1. The default is M=163, K3=7, K2=6, K1=3.
- R4: With `sq_mode` = 1, `result` is `op_a`² reduced by the same polynomial, and `op_b` has no effect.
- R5: A zero `op_a` gives a zero `result` in both modes. A zero `op_b` gives a zero `result` when `sq_mode` = 0.
- R6: The all-ones operand gives the correctly reduced product and square.
- R7: Requests issued on consecutive cycles return their results in issue order, one per cycle, without loss.
- R8: An instance with M=8, taps K3=4, K2=3, K1=1 and base threshold 2 forms correct products for all 65,536 operand pairs and correct squares for all 256 operands. This exercises several levels of recursion.
- R9: `result` holds its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request strobe |
| sq_mode | input | 1 | 1 = square `op_a`, 0 = multiply `op_a` by `op_b` |
| op_a | input | M | First operand, bit i = coefficient of x^i |
| op_b | input | M | Second operand, ignored when squaring |
| done | output | 1 | One-cycle pulse marking a valid `result` |
| result | output | M | Reduced field element |

## Verification
Zero operands show whether stray partial-product terms or reduction taps leak into the result. The all-ones operand drives every reduction fold at once, so a wrong or missing tap shows up there. Random 163-bit operands, issued back to back, separate a faulty Karatsuba middle term or recombination shift from a correct one. They also test ordering and latency. Squares taken with a random, unrelated `op_b` confirm that the interleaving path is selected and that `op_b` is really ignored. The exhaustive 8-bit run with a threshold of 2 reaches every split and recombination boundary of the recursion, against an independent bit-serial shift-and-XOR model.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;

   // operation selected for a request
   typedef enum logic {
      GF_OP_MUL = 1'b0,
      GF_OP_SQR = 1'b1
   } gf_op_e;

   // width of the lower half when a piece of width w is split
   function automatic int lo_width(input int w);
      return (w + 1) / 2;
   endfunction

endpackage

// File: rtl/gf2m_kara_node.sv
// Carry-less product of two W-bit polynomials. Recurses by Karatsuba
// splitting until W <= BASE, then uses a direct AND/XOR array.
module gf2m_kara_node #(
   parameter int W    = 163,
   parameter int BASE = 16
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-2:0] p
);
   import gf2m_pkg::*;

   if (BASE < 1) begin : g_bad_base
      $error("BASE must be at least 1");
   end

   if (W <= BASE) begin : g_school
      logic [2*W-2:0] acc;
      always_comb begin
         acc = '0;
         for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
               acc[i+j] = acc[i+j] ^ (x[i] & y[j]);
            end
         end
      end
      assign p = acc;
   end else begin : g_split
      localparam int LW = lo_width(W);
      localparam int HW = W - LW;

      logic [LW-1:0]     x_lo, y_lo, x_mx, y_mx;
      logic [HW-1:0]     x_hi, y_hi;
      logic [2*LW-2:0]   p_lo, p_mx, mid;
      logic [2*HW-2:0]   p_hi;
      logic [2*W-2:0]    acc;

      always_comb begin
         x_lo = x[LW-1:0];
         y_lo = y[LW-1:0];
         x_hi = x[W-1:LW];
         y_hi = y[W-1:LW];
         x_mx = x_lo;
         y_mx = y_lo;
         x_mx[HW-1:0] = x_mx[HW-1:0] ^ x_hi;
         y_mx[HW-1:0] = y_mx[HW-1:0] ^ y_hi;
      end

      gf2m_kara_node #(.W(LW), .BASE(BASE)) i_lo (.x(x_lo), .y(y_lo), .p(p_lo));
      gf2m_kara_node #(.W(HW), .BASE(BASE)) i_hi (.x(x_hi), .y(y_hi), .p(p_hi));
      gf2m_kara_node #(.W(LW), .BASE(BASE)) i_mx (.x(x_mx), .y(y_mx), .p(p_mx));

      always_comb begin
         // middle term: mixed product minus both outer products
         mid = p_mx ^ p_lo;
         mid[2*HW-2:0] = mid[2*HW-2:0] ^ p_hi;
         acc = '0;
         acc[2*LW-2:0]    = p_lo;
         acc[2*W-2:2*LW]  = p_hi;
         acc[LW +: 2*LW-1] = acc[LW +: 2*LW-1] ^ mid;
      end
      assign p = acc;
   end

endmodule

// File: rtl/gf2m_reduce.sv
// Folds a (2M-1)-bit polynomial modulo x^M + x^K3 + x^K2 + x^K1 + 1.
module gf2m_reduce #(
   parameter int M  = 163,
   parameter int K1 = 3,
   parameter int K2 = 6,
   parameter int K3 = 7
) (
   input  logic [2*M-2:0] full,
   output logic [M-1:0]   r
);
   if (!(K1 > 0 && K2 > K1 && K3 > K2 && K3 < M)) begin : g_bad_taps
      $error("taps must satisfy 0 < K1 < K2 < K3 < M");
   end

   logic [2*M-2:0] t;

   always_comb begin
      t = full;
      // walk from the top so every fold lands on a bit still to be seen
      for (int i = 2*M-2; i >= M; i--) begin
         if (t[i]) begin
            t[i-M]    = ~t[i-M];
            t[i-M+K1] = ~t[i-M+K1];
            t[i-M+K2] = ~t[i-M+K2];
            t[i-M+K3] = ~t[i-M+K3];
         end
      end
   end

   assign r = t[M-1:0];

endmodule

// File: rtl/gf2m_kara_mul.sv
module gf2m_kara_mul #(
   parameter int M       = 163,
   parameter int K1      = 3,
   parameter int K2      = 6,
   parameter int K3      = 7,
   parameter int BASE    = 16,
   parameter bit SQ_PATH = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         sq_mode,
   input  logic [M-1:0] op_a,
   input  logic [M-1:0] op_b,
   output logic         done,
   output logic [M-1:0] result
);
   import gf2m_pkg::*;

   localparam int PW = 2*M - 1;

   if (M < 4) begin : g_bad_m
      $error("M must be at least 4");
   end

   logic [M-1:0]  a_q, b_q;
   gf_op_e        op_q;
   logic          v_q;
   logic [PW-1:0] full;
   logic [M-1:0]  red;

   // stage 1: capture the request
   always_ff @(posedge clk) begin
      if (rst) begin
         a_q  <= '0;
         b_q  <= '0;
         op_q <= GF_OP_MUL;
         v_q  <= 1'b0;
      end else begin
         v_q <= start;
         if (start) begin
            a_q  <= op_a;
            b_q  <= op_b;
            op_q <= sq_mode ? GF_OP_SQR : GF_OP_MUL;
         end
      end
   end

   if (SQ_PATH) begin : g_sq_path
      logic [PW-1:0] prod, spread;
      gf2m_kara_node #(.W(M), .BASE(BASE)) i_root (.x(a_q), .y(b_q), .p(prod));
      always_comb begin
         spread = '0;
         for (int i = 0; i < M; i++) spread[2*i] = a_q[i];
      end
      assign full = (op_q == GF_OP_SQR) ? spread : prod;
   end else begin : g_mul_only
      logic [M-1:0] y_sel;
      assign y_sel = (op_q == GF_OP_SQR) ? a_q : b_q;
      gf2m_kara_node #(.W(M), .BASE(BASE)) i_root (.x(a_q), .y(y_sel), .p(full));
   end

   gf2m_reduce #(.M(M), .K1(K1), .K2(K2), .K3(K3)) i_red (.full(full), .r(red));

   // stage 2: register the reduced element
   always_ff @(posedge clk) begin
      if (rst) begin
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= v_q;
         if (v_q) result <= red;
      end
   end

endmodule

// File: rtl/gf2m_kara_mul_chk.sv
module gf2m_kara_mul_chk #(
   parameter int M = 163
) (
   input logic         clk,
   input logic         rst,
   input logic         start,
   input logic         sq_mode,
   input logic [M-1:0] op_a,
   input logic         done,
   input logic [M-1:0] result
);
   // R2: a request yields done two edges later
   a_r2_done_after_start: assert property (@(posedge clk) disable iff (rst)
      start |-> ##2 done);

   // R2: every done traces back to a request
   a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(start, 2));

   // R5: a zero first operand always yields zero
   a_r5_zero_a: assert property (@(posedge clk) disable iff (rst)
      (start && op_a == '0) |-> ##2 (result == '0));

   // R9: the result only moves together with done
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !done |-> $stable(result));

   // R4: squaring the all-zero/one constants keeps them fixed
   a_r4_square_one: assert property (@(posedge clk) disable iff (rst)
      (start && sq_mode && op_a == M'(1)) |-> ##2 (result == M'(1)));

endmodule

bind gf2m_kara_mul gf2m_kara_mul_chk #(.M(M)) i_chk (
   .clk(clk), .rst(rst), .start(start), .sq_mode(sq_mode),
   .op_a(op_a), .done(done), .result(result)
);

// File: tb/test_gf2m_kara_mul.sv
module test_gf2m_kara_mul;
   localparam int CLK_PERIOD = 10;
   localparam int MB = 163;
   localparam int MS = 8;

   typedef struct {
      logic [MB-1:0] exp;
      int            issue;
      string         tag;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   // big instance (defaults)
   logic          start_b = 1'b0, sq_b = 1'b0;
   logic [MB-1:0] a_b = '0, b_b = '0;
   logic          done_b;
   logic [MB-1:0] res_b;

   // small instance
   logic          start_s = 1'b0, sq_s = 1'b0;
   logic [MS-1:0] a_s = '0, b_s = '0;
   logic          done_s;
   logic [MS-1:0] res_s;

   gf2m_kara_mul i_gf2m_kara_mul (
      .clk(clk), .rst(rst), .start(start_b), .sq_mode(sq_b),
      .op_a(a_b), .op_b(b_b), .done(done_b), .result(res_b));

   gf2m_kara_mul #(.M(MS), .K1(1), .K2(3), .K3(4), .BASE(2)) i_small (
      .clk(clk), .rst(rst), .start(start_s), .sq_mode(sq_s),
      .op_a(a_s), .op_b(b_s), .done(done_s), .result(res_s));

   int    total = 0, bad = 0, cyc = 0;
   item_t q_b[$];
   item_t q_s[$];
   logic [MB-1:0] last_b = '0;
   logic [MS-1:0] last_s = '0;
   bit    finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // bit-serial shift-and-XOR reference, reducing after every shift
   function automatic logic [MB-1:0] ref_mul(input logic [MB-1:0] a, input logic [MB-1:0] b,
                                            input int m, input int k1, input int k2, input int k3);
      logic [MB:0] r, poly;
      poly = '0;
      poly[m] = 1'b1; poly[k3] = 1'b1; poly[k2] = 1'b1; poly[k1] = 1'b1; poly[0] = 1'b1;
      r = '0;
      for (int i = m - 1; i >= 0; i--) begin
         r = r << 1;
         if (r[m]) r = r ^ poly;
         if (b[i]) r = r ^ {1'b0, a};
      end
      return r[MB-1:0];
   endfunction

   function automatic logic [MB-1:0] rnd_big();
      logic [191:0] w;
      w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      return w[MB-1:0];
   endfunction

   task automatic drive_b(input logic [MB-1:0] a, input logic [MB-1:0] b, input logic sq, input string tag);
      item_t it;
      @(negedge clk);
      start_b = 1'b1; a_b = a; b_b = b; sq_b = sq;
      it.exp = ref_mul(a, sq ? a : b, MB, 3, 6, 7);
      it.issue = cyc; it.tag = tag;
      q_b.push_back(it);
   endtask

   task automatic drive_s(input logic [MS-1:0] a, input logic [MS-1:0] b, input logic sq);
      item_t it;
      @(negedge clk);
      start_s = 1'b1; a_s = a; b_s = b; sq_s = sq;
      it.exp = ref_mul(MB'(a), MB'(sq ? a : b), MS, 1, 3, 4);
      it.issue = cyc; it.tag = "R8";
      q_s.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start_b = 1'b0; start_s = 1'b0;
      end
   endtask

   // scoreboard monitors
   always @(negedge clk) begin
      if (!rst && !finished) begin
         if (done_b) begin
            if (q_b.size() == 0) begin
               total++; bad++;
               $display("FAIL R2 big: done without request act=1 exp=0");
            end else begin
               item_t it;
               it = q_b.pop_front();
               total++;
               if (res_b !== it.exp) begin
                  bad++;
                  $display("FAIL %s big: act=%h exp=%h", it.tag, res_b, it.exp);
               end
               total++;
               if (cyc - it.issue != 2) begin
                  bad++;
                  $display("FAIL R2 big latency: act=%0d exp=2", cyc - it.issue);
               end
            end
         end else begin
            total++;
            if (res_b !== last_b) begin
               bad++;
               $display("FAIL R9 big hold: act=%h exp=%h", res_b, last_b);
            end
         end
         if (done_s) begin
            if (q_s.size() == 0) begin
               total++; bad++;
               $display("FAIL R2 small: done without request act=1 exp=0");
            end else begin
               item_t it;
               it = q_s.pop_front();
               total++;
               if (res_s !== it.exp[MS-1:0]) begin
                  bad++;
                  $display("FAIL %s small: act=%h exp=%h", it.tag, res_s, it.exp[MS-1:0]);
               end
               total++;
               if (cyc - it.issue != 2) begin
                  bad++;
                  $display("FAIL R2 small latency: act=%0d exp=2", cyc - it.issue);
               end
            end
         end else begin
            total++;
            if (res_s !== last_s) begin
               bad++;
               $display("FAIL R9 small hold: act=%h exp=%h", res_s, last_s);
            end
         end
      end
      last_b = res_b;
      last_s = res_s;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: act=timeout exp=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [MB-1:0] ones;
      ones = '1;
      repeat (3) @(negedge clk);
      // R1: reset state
      total++;
      if (done_b !== 1'b0 || res_b !== '0 || done_s !== 1'b0 || res_s !== '0) begin
         bad++;
         $display("FAIL R1 in reset: act=%b/%h exp=0/0", done_b, res_b);
      end
      rst = 1'b0;
      idle(3);
      total++;
      if (done_b !== 1'b0 || res_b !== '0) begin
         bad++;
         $display("FAIL R1 after reset: act=%b/%h exp=0/0", done_b, res_b);
      end

      // R5: zero operands
      drive_b('0, rnd_big(), 1'b0, "R5");
      drive_b(rnd_big(), '0, 1'b0, "R5");
      drive_b('0, rnd_big(), 1'b1, "R5");
      idle(3);
      // R6: all-ones operand
      drive_b(ones, ones, 1'b0, "R6");
      drive_b(ones, MB'(1), 1'b0, "R6");
      drive_b(ones, rnd_big(), 1'b1, "R6");
      idle(3);
      // R3: products spanning the reduction boundary
      drive_b(MB'(1) << (MB-1), MB'(1) << (MB-1), 1'b0, "R3");
      drive_b(MB'(2), MB'(1) << (MB-1), 1'b0, "R3");
      idle(3);
      // R7/R3: back-to-back random products
      for (int i = 0; i < 300; i++) drive_b(rnd_big(), rnd_big(), 1'b0, "R7");
      idle(3);
      // R4: squares with an unrelated op_b
      for (int i = 0; i < 100; i++) drive_b(rnd_big(), rnd_big(), 1'b1, "R4");
      idle(3);
      // R3: spaced random products
      for (int i = 0; i < 50; i++) begin
         drive_b(rnd_big(), rnd_big(), 1'b0, "R3");
         idle(1 + (i % 3));
      end
      idle(4);

      // R8: exhaustive small field
      for (int a = 0; a < (1 << MS); a++) begin
         for (int b = 0; b < (1 << MS); b++) drive_s(MS'(a), MS'(b), 1'b0);
      end
      for (int a = 0; a < (1 << MS); a++) drive_s(MS'(a), MS'(a ^ 8'h5a), 1'b1);
      idle(5);

      total++;
      if (q_b.size() != 0 || q_s.size() != 0) begin
         bad++;
         $display("FAIL R2 outstanding: act=%0d exp=0", q_b.size() + q_s.size());
      end
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule